// File: doc/BRIEF.md
# Instruction Prefetch Queue with Per-Clock Status

This block sits between a 16-bit instruction fetch port and a decoder that takes one byte at a time. It holds a small first-in-first-out store of instruction bytes and keeps it topped up. Whenever no fetch is outstanding and at least two byte slots are free, it raises a word request at its current fetch address. The bus side accepts the request with a one-cycle acknowledge and later returns the data word. A fetch issued at an odd address delivers only the upper byte of the returned word. After that, the fetch address is word-aligned.

The decoder sees the oldest byte on a valid/data pair and takes it with a pop strobe. With the pop it says whether that byte opens a new instruction or continues the current one. When the queue is empty, a returning byte is offered to the decoder in the same cycle it arrives. A branch is signalled by a flush carrying the new target address. The flush empties the store, reloads the fetch address and marks any fetch already in flight so that its data is thrown away when it arrives.

Each clock's queue activity is reported one cycle later on a 2-bit status output. External logic uses this status to follow which bytes the decoder consumed.

Top module: `prefetch_queue`

## Requirements
- R1: The store holds at most DEPTH (default 6) bytes. Bytes leave on `byte_out` in the order they arrived. `byte_vld` is high whenever a byte is available, and `byte_out` then shows the oldest byte.
- R2: `fetch_req` is high exactly when no fetch is outstanding and at least 2 slots are free. A fetch is issued in a cycle where `fetch_req` and `fetch_ack` are both high. Only one fetch is outstanding at a time, so `fetch_req` is low in the cycle after an issue.
- R3: With the store empty, a usable response makes `byte_vld` high and puts its first byte on `byte_out` in the same cycle. If that byte is popped in that cycle, it is not stored.
- R4: A `flush` empties the store at the next edge. `byte_vld` is low in the following cycle, and `fetch_addr` then equals the flush target.
- R5: A response to a fetch issued before a flush is discarded. This includes a response that arrives in the flush cycle itself, and a fetch issued in that cycle.
- R6: A fetch at an odd address stores only `rsp_data[15:8]` and advances the fetch address by 1. A fetch at an even address stores `rsp_data[7:0]` and then `rsp_data[15:8]`, and advances the address by 2.
- R7: `qstat` encodings: 2'b00 means nothing was taken, 2'b01 means a byte marked as first opcode byte (`pop_first`=1) was taken, 2'b10 means the queue was flushed, and 2'b11 means a byte marked subsequent (`pop_first`=0) was taken.
- R8: `qstat` describes the operation of the previous clock. When a flush and a pop occur in the same clock, the flush code is reported.
- R9: A pop while `byte_vld` is low is ignored: the store is unchanged and `qstat` is 2'b00 in the next cycle.
- R10: A response and a pop in the same clock both take effect. The byte count changes by the bytes stored minus one.
- R11: During and after synchronous reset the store is empty, no fetch is outstanding, `qstat` is 2'b00, and `fetch_addr` equals RESET_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | output | 1 | Request for a word fetch |
| fetch_addr | output | ADDR_W | Byte address of the requested fetch |
| fetch_ack | input | 1 | Bus accepts the request this cycle |
| rsp_vld | input | 1 | Response word for the outstanding fetch |
| rsp_data | input | 16 | Response word |
| flush | input | 1 | Empty the queue and redirect fetching |
| flush_addr | input | ADDR_W | New fetch address on flush |
| pop | input | 1 | Decoder takes the head byte |
| pop_first | input | 1 | Taken byte is the first byte of an instruction |
| byte_vld | output | 1 | A byte is available |
| byte_out | output | 8 | Oldest available byte |
| qstat | output | 2 | Queue operation of the previous clock |

## Verification
A behavioural byte queue in the bench tracks the design through four kinds of traffic, each aimed at different behaviour:

- An always-acknowledging bus with no pops fills the store. This shows whether the request stops at the free-space limit.
- A directed flush to an odd target exposes errors in the single-byte fetch and the address re-alignment that follows.
- Random acknowledges, latencies, pops and occasional flushes make the store run empty, full and mid-level in turn. This separates the bypass path, simultaneous store and take, discarded in-flight data and ignored pops.
- Pops are biased towards first and subsequent markings so that status codes 2'b01 and 2'b11 are both distinguished.

// File: rtl/pq_pkg.sv
package pq_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int FETCH_BYTES = WORD_W / BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

    // bytes delivered by one accepted response, oldest in b0
    typedef struct packed {
        logic [1:0] cnt;
        byte_t      b0;
        byte_t      b1;
    } push_t;

    // circular index advance; inc never exceeds depth
    function automatic int unsigned ring_add(int unsigned idx, int unsigned inc,
                                             int unsigned depth);
        int unsigned s;
        s = idx + inc;
        return (s >= depth) ? s - depth : s;
    endfunction

    function automatic qstat_e status_of(logic flushed, logic took, logic first);
        if (flushed)   return QS_FLUSH;
        else if (took) return first ? QS_FIRST : QS_NEXT;
        else           return QS_IDLE;
    endfunction

endpackage

// File: rtl/pq_store.sv
module pq_store
    import pq_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  push_t                      push,
    input  logic                       pop_ok,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       avail,
    output byte_t                      head
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    byte_t          mem [DEPTH];
    logic [IW-1:0]  rd_idx, wr_idx, wr_idx1;
    logic [CW-1:0]  cnt_q;
    logic           skip;
    logic [1:0]     n_wr;
    byte_t          src0;

    // when empty, a byte taken in the arrival cycle bypasses the store
    assign skip    = pop_ok && (cnt_q == '0);
    assign n_wr    = push.cnt - {1'b0, skip};
    assign src0    = skip ? push.b1 : push.b0;
    assign wr_idx1 = IW'(ring_add(32'(wr_idx), 1, DEPTH));

    assign count = cnt_q;
    assign avail = (cnt_q != '0) || (push.cnt != 2'd0);
    assign head  = (cnt_q != '0) ? mem[rd_idx] : push.b0;

    always_ff @(posedge clk) begin
        if (!clr && n_wr != 2'd0) mem[wr_idx] <= src0;
        if (!clr && n_wr == 2'd2) mem[wr_idx1] <= push.b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_idx <= '0;
            wr_idx <= '0;
            cnt_q  <= '0;
        end else begin
            wr_idx <= IW'(ring_add(32'(wr_idx), 32'(n_wr), DEPTH));
            if (pop_ok && cnt_q != '0)
                rd_idx <= IW'(ring_add(32'(rd_idx), 1, DEPTH));
            cnt_q <= cnt_q + CW'(push.cnt) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/pq_fetch.sv
module pq_fetch
    import pq_pkg::*;
#(
    parameter int          DEPTH      = 6,
    parameter int          ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       flush,
    input  logic [ADDR_W-1:0]          flush_addr,
    input  logic                       fetch_ack,
    input  logic                       rsp_vld,
    input  logic [WORD_W-1:0]          rsp_data,
    output logic                       fetch_req,
    output logic [ADDR_W-1:0]          fetch_addr,
    output push_t                      push
);
    localparam int CW   = $clog2(DEPTH+1);
    localparam int ROOM = DEPTH - FETCH_BYTES;

    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic              pend_q, pend_d;
    logic              drop_q, drop_d;
    logic              odd_q,  odd_d;
    logic              issue, take;

    assign fetch_req  = !pend_q && (count <= CW'(ROOM));
    assign fetch_addr = ptr_q;
    assign issue      = fetch_req && fetch_ack;
    assign take       = rsp_vld && pend_q && !drop_q && !flush;

    always_comb begin
        push.cnt = 2'd0;
        push.b0  = odd_q ? rsp_data[15:8] : rsp_data[7:0];
        push.b1  = rsp_data[15:8];
        if (take) push.cnt = odd_q ? 2'd1 : 2'd2;
    end

    always_comb begin
        ptr_d  = ptr_q;
        pend_d = pend_q;
        drop_d = drop_q;
        odd_d  = odd_q;
        if (rsp_vld && pend_q) begin
            pend_d = 1'b0;
            drop_d = 1'b0;
        end
        if (issue) begin
            pend_d = 1'b1;
            drop_d = 1'b0;
            odd_d  = ptr_q[0];
            ptr_d  = ptr_q + (ptr_q[0] ? ADDR_W'(1) : ADDR_W'(FETCH_BYTES));
        end
        if (flush) begin
            drop_d = pend_d;
            ptr_d  = flush_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= RESET_ADDR;
            pend_q <= 1'b0;
            drop_q <= 1'b0;
            odd_q  <= 1'b0;
        end else begin
            ptr_q  <= ptr_d;
            pend_q <= pend_d;
            drop_q <= drop_d;
            odd_q  <= odd_d;
        end
    end
endmodule

// File: rtl/pq_status.sv
module pq_status
    import pq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  logic   pop_ok,
    input  logic   pop_first,
    output qstat_e qs
);
    always_ff @(posedge clk) begin
        if (rst) qs <= QS_IDLE;
        else     qs <= status_of(flush, pop_ok, pop_first);
    end
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pq_pkg::*;
#(
    parameter int                DEPTH      = 6,
    parameter int                ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ack,
    input  logic              rsp_vld,
    input  logic [15:0]       rsp_data,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              pop,
    input  logic              pop_first,
    output logic              byte_vld,
    output logic [7:0]        byte_out,
    output logic [1:0]        qstat
);
    localparam int CW = $clog2(DEPTH+1);

    push_t          push;
    logic [CW-1:0]  q_count;
    logic           pop_ok;
    qstat_e         qs;

    assign pop_ok = pop && byte_vld && !flush;
    assign qstat  = qs;

    pq_fetch #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk(clk), .rst(rst), .count(q_count),
        .flush(flush), .flush_addr(flush_addr),
        .fetch_ack(fetch_ack), .rsp_vld(rsp_vld), .rsp_data(rsp_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .push(push)
    );

    pq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .clr(flush), .push(push), .pop_ok(pop_ok),
        .count(q_count), .avail(byte_vld), .head(byte_out)
    );

    pq_status u_status (
        .clk(clk), .rst(rst), .flush(flush), .pop_ok(pop_ok),
        .pop_first(pop_first), .qs(qs)
    );
endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
    parameter int DEPTH = 6
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       flush,
    input logic                       pop,
    input logic                       byte_vld,
    input logic                       fetch_req,
    input logic                       fetch_ack,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic [1:0]                 qstat
);
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH);

    a_r2_req_needs_room: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> count <= DEPTH - 2);

    a_r2_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        fetch_req && fetch_ack |=> !fetch_req);

    a_r4_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> count == 0 && !byte_vld);

    a_r8_flush_code: assert property (@(posedge clk) disable iff (rst)
        flush |=> qstat == 2'b10);

    a_r9_idle_code: assert property (@(posedge clk) disable iff (rst)
        !flush && !(pop && byte_vld) |=> qstat == 2'b00);
endmodule

bind prefetch_queue pq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .pop(pop), .byte_vld(byte_vld),
    .fetch_req(fetch_req), .fetch_ack(fetch_ack), .count(q_count),
    .qstat(qstat)
);

// File: tb/sim_prefetch_queue.sv
`timescale 1ns/100ps
module sim_prefetch_queue;
    localparam int DEPTH = 6;
    localparam int AW    = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          fetch_req, fetch_ack, rsp_vld, flush, pop, pop_first;
    logic [AW-1:0] fetch_addr, flush_addr;
    logic [15:0]   rsp_data;
    logic          byte_vld;
    logic [7:0]    byte_out;
    logic [1:0]    qstat;

    prefetch_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .RESET_ADDR('0)) u0 (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .rsp_vld(rsp_vld), .rsp_data(rsp_data),
        .flush(flush), .flush_addr(flush_addr), .pop(pop), .pop_first(pop_first),
        .byte_vld(byte_vld), .byte_out(byte_out), .qstat(qstat)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model state
    logic [7:0]    mq[$];
    bit            m_pend, m_drop, m_odd;
    logic [AW-1:0] m_ptr;
    logic [1:0]    m_qs;
    bit            prev_flush, prev_pushpop, prev_idlepop, first_chk;
    // bus responder state
    bit            b_pend;
    logic [AW-1:0] b_addr;
    int            b_lat;

    function automatic logic [7:0] bval(logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    function automatic logic [15:0] word_at(logic [AW-1:0] a);
        logic [AW-1:0] al;
        al = {a[AW-1:1], 1'b0};
        return {bval(al + 1'b1), bval(al)};
    endfunction

    task automatic model_step();
        logic [7:0] inb[$];
        bit exp_req, use_rsp, exp_vld, pop_ok, acc;
        logic [7:0] exp_byte;
        string tag;
        exp_req = !m_pend && (DEPTH - mq.size() >= 2);
        use_rsp = rsp_vld && m_pend && !m_drop && !flush;
        if (use_rsp) begin
            if (m_odd) inb.push_back(rsp_data[15:8]);
            else begin
                inb.push_back(rsp_data[7:0]);
                inb.push_back(rsp_data[15:8]);
            end
        end
        exp_vld  = (mq.size() > 0) || use_rsp;
        exp_byte = (mq.size() > 0) ? mq[0] : (use_rsp ? inb[0] : 8'h00);

        if (first_chk)                                tag = "R11";
        else if (prev_flush)                          tag = "R4";
        else if (rsp_vld && m_pend && !use_rsp)       tag = "R5";
        else if (mq.size() == 0 && use_rsp)           tag = "R3";
        else if (prev_pushpop)                        tag = "R10";
        else if (prev_idlepop)                        tag = "R9";
        else                                          tag = "R1";

        chk(fetch_req == exp_req, first_chk ? "R11 fetch_req" : "R2 fetch_req",
            32'(fetch_req), 32'(exp_req));
        chk(fetch_addr == m_ptr, first_chk ? "R11 fetch_addr" : "R6 fetch_addr",
            32'(fetch_addr), 32'(m_ptr));
        chk(byte_vld == exp_vld, {tag, " byte_vld"}, 32'(byte_vld), 32'(exp_vld));
        if (exp_vld)
            chk(byte_out == exp_byte, {tag, " byte_out"}, 32'(byte_out), 32'(exp_byte));
        chk(qstat == m_qs, (m_qs == 2'b00) ? "R7 qstat" : "R8 qstat",
            32'(qstat), 32'(m_qs));
        first_chk = 0;

        // advance model across the edge
        pop_ok = pop && exp_vld && !flush;
        if (flush) mq.delete();
        else begin
            foreach (inb[i]) mq.push_back(inb[i]);
            if (pop_ok) void'(mq.pop_front());
        end
        m_qs = flush ? 2'b10 : (pop_ok ? (pop_first ? 2'b01 : 2'b11) : 2'b00);
        prev_flush   = flush;
        prev_pushpop = use_rsp && pop_ok;
        prev_idlepop = pop && !exp_vld && !flush;
        acc = exp_req && fetch_ack;
        if (rsp_vld && m_pend) begin
            m_pend = 0;
            m_drop = 0;
        end
        if (acc) begin
            m_pend = 1;
            m_drop = 0;
            m_odd  = m_ptr[0];
            m_ptr  = m_ptr + (m_ptr[0] ? 20'd1 : 20'd2);
        end
        if (flush) begin
            m_drop = m_pend;
            m_ptr  = flush_addr;
        end

        // bus responder
        if (rsp_vld) b_pend = 0;
        else if (b_pend && b_lat > 0) b_lat--;
        if (fetch_req && fetch_ack) begin
            b_pend = 1;
            b_addr = fetch_addr;
            b_lat  = int'($urandom % 3);
        end
    endtask

    task automatic drive(int p_ack, int p_pop, int p_flush, bit force_flush,
                         logic [AW-1:0] tgt);
        @(posedge clk);
        #1;
        fetch_ack  = ($urandom % 100) < p_ack;
        rsp_vld    = b_pend && (b_lat == 0);
        rsp_data   = word_at(b_addr);
        flush      = force_flush || (($urandom % 100) < p_flush);
        flush_addr = force_flush ? tgt : AW'($urandom);
        pop        = ($urandom % 100) < p_pop;
        pop_first  = $urandom % 2;
        @(negedge clk);
        model_step();
    endtask

    initial begin
        rst = 1; fetch_ack = 0; rsp_vld = 0; rsp_data = '0; flush = 0;
        flush_addr = '0; pop = 0; pop_first = 0;
        mq.delete(); m_pend = 0; m_drop = 0; m_odd = 0; m_ptr = '0; m_qs = 2'b00;
        prev_flush = 0; prev_pushpop = 0; prev_idlepop = 0; first_chk = 1;
        b_pend = 0; b_addr = '0; b_lat = 0;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        // R11 checked on the first cycle; fill with no pops (R2 limit)
        for (int i = 0; i < 30; i++) drive(100, 0, 0, 0, '0);
        // R6: redirect to an odd target
        drive(100, 0, 0, 1, 20'h00133);
        for (int i = 0; i < 50; i++) drive(100, 50, 0, 0, '0);
        // R9: pops against an empty queue with the bus stalled
        drive(0, 0, 0, 1, 20'h00400);
        for (int i = 0; i < 10; i++) drive(0, 100, 0, 0, '0);
        // mixed traffic: R3, R5, R7, R10
        for (int i = 0; i < 3000; i++) drive(70, 60, 3, 0, '0);
        for (int i = 0; i < 500; i++) drive(40, 90, 2, 0, '0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule